// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Carry

This block is a purely combinational byte-wide arithmetic and logic unit for a small controller core. It takes an operation selector, a destination operand (`opA`) and a source operand (`opB`, which is also the immediate value), and the current status byte. In the same evaluation it returns the result and the updated status byte. Multiply is the only operation that fills the upper result byte. Writing the result back to a register file is left to the caller.

Each operation has its own flag rule. Some operations derive the carry from the arithmetic. Some force the carry to a constant. Others leave every flag alone. Clear is the only operation that writes flags other than the carry. Status bits that an operation does not write pass through from `statusIn` to `statusOut` unchanged.

Top module: `alu8_carry_unit`

## Requirements
- R1: The status byte uses these bit positions: C is bit 7, Z is bit 6, N is bit 5, V is bit 4, S is bit 3. Bits 2..0 (H, T, I) are never altered by any operation, and every status bit that an operation does not name is copied from input to output.
- R2: Code 0 (add) gives the low byte of A+B and sets C to bit 8 of the sum. Code 1 (add with carry) adds the input C to that sum in the same way.
- R3: Code 2 (subtract) gives the low byte of A-B. Code 3 (subtract with carry) gives the low byte of A-B-C. For both, C is set exactly when the true difference is negative.
- R4: Code 4 (subtract immediate with carry) gives the low byte of A-B-C and leaves all flags unchanged.
- R5: Code 5 (arithmetic shift right) shifts A right by one place, keeps bit 7, and loads C with the old bit 0.
- R6: Code 6 (one's complement) gives 0xFF-A and sets C to 1.
- R7: Code 7 (negate) gives the low byte of 0-A and leaves all flags unchanged.
- R8: Code 8 (decrement, giving the low byte of A-1) and code 9 (exclusive-or of A and B) leave all flags unchanged.
- R9: Code 10 (clear) gives 0, sets Z, clears S, V and N, and leaves C unchanged.
- R10: Code 11 (move) and code 12 (load immediate) output B with no flag change.
- R11: Code 13 (unsigned multiply) outputs the 16-bit product A*B on {resultHi, resultLo} and sets C to product bit 15.
- R12: For every code other than 13, resultHi is 0. Codes 14 and 15 output A with no flag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 4 | Operation selector (codes listed in the requirements) |
| opA | input | 8 | Destination operand |
| opB | input | 8 | Source operand or immediate value |
| statusIn | input | 8 | Current status byte |
| resultLo | output | 8 | Result low byte |
| resultHi | output | 8 | Product high byte; zero for all other operations |
| statusOut | output | 8 | Updated status byte |

## Verification
The incoming carry is consumed and the outgoing carry is produced in the same evaluation. A wrap or borrow can therefore come from the incoming carry alone.

The bench provokes this case with add-with-carry on 0xFF+0x00 and with the subtract-with-carry forms on equal operands. In each case the result and C flip only because of C. These cases are judged against an arithmetic model in the bench that works on wide integers.

Clear meets carry preservation in one operation: it writes four flags while holding C. It is applied with both values of C.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_S = 3;
  localparam int FLAG_V = 4;
  localparam int FLAG_N = 5;
  localparam int FLAG_Z = 6;
  localparam int FLAG_C = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_SBCI = 4'd4,
    OP_ASR  = 4'd5,
    OP_COM  = 4'd6,
    OP_NEG  = 4'd7,
    OP_DEC  = 4'd8,
    OP_EOR  = 4'd9,
    OP_CLR  = 4'd10,
    OP_MOV  = 4'd11,
    OP_LDI  = 4'd12,
    OP_MUL  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    SEL_SUM, SEL_DIFF, SEL_ASR, SEL_NOT, SEL_NEG, SEL_DEC,
    SEL_XOR, SEL_ZERO, SEL_PASSB, SEL_MUL, SEL_PASSA
  } resSel_e;

  typedef enum logic [2:0] {
    CY_KEEP, CY_SUM, CY_BORROW, CY_LSB, CY_ONE, CY_MULTOP
  } carryMode_e;

  typedef struct packed {
    resSel_e    resSel;
    logic       useCarryIn;
    carryMode_e carryMode;
    logic       clearFlags;
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{resSel: SEL_PASSA, useCarryIn: 1'b0, carryMode: CY_KEEP, clearFlags: 1'b0};
    unique case (aluOp_e'(opCode))
      OP_ADD:  begin ctrl.resSel = SEL_SUM;  ctrl.carryMode = CY_SUM; end
      OP_ADC:  begin ctrl.resSel = SEL_SUM;  ctrl.carryMode = CY_SUM; ctrl.useCarryIn = 1'b1; end
      OP_SUB:  begin ctrl.resSel = SEL_DIFF; ctrl.carryMode = CY_BORROW; end
      OP_SBC:  begin ctrl.resSel = SEL_DIFF; ctrl.carryMode = CY_BORROW; ctrl.useCarryIn = 1'b1; end
      OP_SBCI: begin ctrl.resSel = SEL_DIFF; ctrl.useCarryIn = 1'b1; end
      OP_ASR:  begin ctrl.resSel = SEL_ASR;  ctrl.carryMode = CY_LSB; end
      OP_COM:  begin ctrl.resSel = SEL_NOT;  ctrl.carryMode = CY_ONE; end
      OP_NEG:  ctrl.resSel = SEL_NEG;
      OP_DEC:  ctrl.resSel = SEL_DEC;
      OP_EOR:  ctrl.resSel = SEL_XOR;
      OP_CLR:  begin ctrl.resSel = SEL_ZERO; ctrl.clearFlags = 1'b1; end
      OP_MOV,
      OP_LDI:  ctrl.resSel = SEL_PASSB;
      OP_MUL:  begin ctrl.resSel = SEL_MUL; ctrl.carryMode = CY_MULTOP; end
      default: ctrl.resSel = SEL_PASSA;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluCtrl_t           ctrl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [7:0]         statusIn,
  output logic [WIDTH-1:0]   resultLo,
  output logic [WIDTH-1:0]   resultHi,
  output logic [7:0]         statusOut
);

  localparam int EXT = WIDTH + 1;
  localparam int PROD = 2 * WIDTH;

  logic             cin;
  logic [EXT-1:0]   sumExt;
  logic [EXT-1:0]   diffExt;
  logic [PROD-1:0]  product;
  logic             carryNext;

  assign cin     = ctrl.useCarryIn & statusIn[FLAG_C];
  assign sumExt  = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, cin};
  assign diffExt = {1'b0, opA} - {1'b0, opB} - {{WIDTH{1'b0}}, cin};
  assign product = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};

  always_comb begin
    resultHi = '0;
    unique case (ctrl.resSel)
      SEL_SUM:   resultLo = sumExt[WIDTH-1:0];
      SEL_DIFF:  resultLo = diffExt[WIDTH-1:0];
      SEL_ASR:   resultLo = {opA[WIDTH-1], opA[WIDTH-1:1]};
      SEL_NOT:   resultLo = ~opA;
      SEL_NEG:   resultLo = '0 - opA;
      SEL_DEC:   resultLo = opA - {{(WIDTH-1){1'b0}}, 1'b1};
      SEL_XOR:   resultLo = opA ^ opB;
      SEL_ZERO:  resultLo = '0;
      SEL_PASSB: resultLo = opB;
      SEL_MUL:   begin resultLo = product[WIDTH-1:0]; resultHi = product[PROD-1:WIDTH]; end
      default:   resultLo = opA;
    endcase
  end

  always_comb begin
    unique case (ctrl.carryMode)
      CY_SUM:    carryNext = sumExt[WIDTH];
      CY_BORROW: carryNext = diffExt[WIDTH];
      CY_LSB:    carryNext = opA[0];
      CY_ONE:    carryNext = 1'b1;
      CY_MULTOP: carryNext = product[PROD-1];
      default:   carryNext = statusIn[FLAG_C];
    endcase
  end

  always_comb begin
    statusOut         = statusIn;
    statusOut[FLAG_C] = carryNext;
    if (ctrl.clearFlags) begin
      statusOut[FLAG_Z] = 1'b1;
      statusOut[FLAG_S] = 1'b0;
      statusOut[FLAG_V] = 1'b0;
      statusOut[FLAG_N] = 1'b0;
    end
  end

endmodule

// File: rtl/alu8_carry_unit.sv
module alu8_carry_unit
  import alu8_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic [7:0] statusIn,
  output logic [7:0] resultLo,
  output logic [7:0] resultHi,
  output logic [7:0] statusOut
);

  aluCtrl_t ctrl;

  alu8_ctrl ctrl_i (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu8_datapath #(.WIDTH(8)) dp_i (
    .ctrl      (ctrl),
    .opA       (opA),
    .opB       (opB),
    .statusIn  (statusIn),
    .resultLo  (resultLo),
    .resultHi  (resultHi),
    .statusOut (statusOut)
  );

endmodule

// File: rtl/alu8_carry_unit_chk.sv
module alu8_carry_unit_chk
  import alu8_pkg::*;
(
  input logic [3:0] opCode,
  input logic [7:0] opA,
  input logic [7:0] opB,
  input logic [7:0] statusIn,
  input logic [7:0] resultLo,
  input logic [7:0] resultHi,
  input logic [7:0] statusOut
);

  logic flagsFrozen;
  assign flagsFrozen = (opCode == OP_SBCI) || (opCode == OP_NEG) || (opCode == OP_DEC) ||
                       (opCode == OP_EOR) || (opCode == OP_MOV) || (opCode == OP_LDI) ||
                       (opCode == OP_RSV0) || (opCode == OP_RSV1);

  always_comb begin
    assert_low_flags_kept_R1: assert (statusOut[2:0] == statusIn[2:0]);
    if (opCode == OP_COM)
      assert_com_carry_set_R6: assert (statusOut[FLAG_C] && resultLo == 8'(~opA));
    if (opCode == OP_CLR)
      assert_clear_flags_R9: assert (resultLo == 8'h00 && statusOut == {statusIn[7], 1'b1, 3'b000, statusIn[2:0]});
    if (flagsFrozen)
      assert_flags_frozen_R8: assert (statusOut == statusIn);
    if (opCode == OP_MUL)
      assert_mul_product_R11: assert ({resultHi, resultLo} == 16'(opA * opB) && statusOut[FLAG_C] == resultHi[7]);
    else
      assert_hi_zero_R12: assert (resultHi == 8'h00);
    if (opCode == OP_ASR)
      assert_asr_sign_R5: assert (resultLo[7] == opA[7] && statusOut[FLAG_C] == opA[0]);
  end

endmodule

bind alu8_carry_unit alu8_carry_unit_chk chk_i (
  .opCode    (opCode),
  .opA       (opA),
  .opB       (opB),
  .statusIn  (statusIn),
  .resultLo  (resultLo),
  .resultHi  (resultHi),
  .statusOut (statusOut)
);

// File: tb/alu8_carry_unit_tb_top.sv
module alu8_carry_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] opCode;
  logic [7:0] opA, opB, statusIn;
  logic [7:0] resultLo, resultHi, statusOut;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  alu8_carry_unit dut_i (
    .opCode (opCode), .opA (opA), .opB (opB), .statusIn (statusIn),
    .resultLo (resultLo), .resultHi (resultHi), .statusOut (statusOut)
  );

  function automatic logic [23:0] refModel(input int op, input int a, input int b, input logic [7:0] f);
    int r; int hi; logic [7:0] nf; int c;
    nf = f; c = f[7]; hi = 0; r = a;
    case (op)
      0:  begin r = a + b;     nf[7] = (r > 255); end
      1:  begin r = a + b + c; nf[7] = (r > 255); end
      2:  begin r = a - b;     nf[7] = (r < 0); end
      3:  begin r = a - b - c; nf[7] = (r < 0); end
      4:  r = a - b - c;
      5:  begin r = (a / 2) + (a >= 128 ? 128 : 0); nf[7] = a[0]; end
      6:  begin r = 255 - a; nf[7] = 1'b1; end
      7:  r = 0 - a;
      8:  r = a - 1;
      9:  r = a ^ b;
      10: begin r = 0; nf[6] = 1'b1; nf[5] = 1'b0; nf[4] = 1'b0; nf[3] = 1'b0; end
      11, 12: r = b;
      13: begin r = a * b; hi = r / 256; nf[7] = (r >= 32768); end
      default: r = a;
    endcase
    return {nf, hi[7:0], r[7:0]};
  endfunction

  task automatic applyCheck(input string req, input int op, input int a, input int b, input logic [7:0] f);
    logic [23:0] exp;
    @(negedge clk);
    opCode = op[3:0]; opA = a[7:0]; opB = b[7:0]; statusIn = f;
    #5;
    exp = refModel(op, a, b, f);
    checkCount++;
    if ({statusOut, resultHi, resultLo} !== exp) begin
      failCount++;
      $display("FAIL %s op=%0d a=%h b=%h f=%h: got st=%h hi=%h lo=%h expected st=%h hi=%h lo=%h",
               req, op, a[7:0], b[7:0], f, statusOut, resultHi, resultLo, exp[23:16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic testReset();
    applyCheck("R2", 0, 0, 0, 8'h00);
  endtask

  task automatic testAdd();
    applyCheck("R2", 0, 8'hF0, 8'h10, 8'h00);
    applyCheck("R2", 0, 8'h12, 8'h34, 8'h80);
    applyCheck("R2", 1, 8'hFF, 8'h00, 8'h80);
    applyCheck("R2", 1, 8'hFF, 8'h00, 8'h00);
    applyCheck("R2", 1, 8'h7F, 8'h80, 8'h87);
  endtask

  task automatic testSub();
    applyCheck("R3", 2, 8'h05, 8'h06, 8'h00);
    applyCheck("R3", 2, 8'h06, 8'h06, 8'h80);
    applyCheck("R3", 3, 8'h05, 8'h05, 8'h80);
    applyCheck("R3", 3, 8'h05, 8'h05, 8'h00);
    applyCheck("R3", 3, 8'h00, 8'hFF, 8'h80);
  endtask

  task automatic testSbci();
    applyCheck("R4", 4, 8'h00, 8'h01, 8'h80);
    applyCheck("R4", 4, 8'h10, 8'h01, 8'h47);
  endtask

  task automatic testAsr();
    applyCheck("R5", 5, 8'h81, 0, 8'h00);
    applyCheck("R5", 5, 8'h42, 0, 8'h80);
  endtask

  task automatic testCom();
    applyCheck("R6", 6, 8'h3C, 0, 8'h00);
  endtask

  task automatic testNeg();
    applyCheck("R7", 7, 8'h01, 0, 8'h80);
    applyCheck("R7", 7, 8'h00, 0, 8'h00);
  endtask

  task automatic testDecEor();
    applyCheck("R8", 8, 8'h00, 0, 8'hFF);
    applyCheck("R8", 9, 8'hA5, 8'h0F, 8'h80);
  endtask

  task automatic testClr();
    applyCheck("R9", 10, 8'hAA, 8'h55, 8'hBF);
    applyCheck("R9", 10, 8'hAA, 8'h55, 8'h38);
  endtask

  task automatic testMovLdi();
    applyCheck("R10", 11, 8'h11, 8'h99, 8'h80);
    applyCheck("R10", 12, 8'h11, 8'h5A, 8'h07);
  endtask

  task automatic testMul();
    applyCheck("R11", 13, 8'hFF, 8'hFF, 8'h00);
    applyCheck("R11", 13, 8'h80, 8'h01, 8'h80);
    applyCheck("R11", 13, 8'h10, 8'h10, 8'h00);
  endtask

  task automatic testUnused();
    applyCheck("R12", 14, 8'h77, 8'h22, 8'h81);
    applyCheck("R12", 15, 8'h01, 8'h02, 8'h7E);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(15);
      applyCheck("R1", op, $urandom_range(255), $urandom_range(255), 8'($urandom_range(255)));
    end
  endtask

  initial begin
    opCode = '0; opA = '0; opB = '0; statusIn = '0;
    repeat (3) @(posedge clk);
    testReset();
    rstN = 1'b1;
    testAdd();
    testSub();
    testSbci();
    testAsr();
    testCom();
    testNeg();
    testDecEor();
    testClr();
    testMovLdi();
    testMul();
    testUnused();
    testRandom();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule